// File: doc/BRIEF.md
# Page-Walk Address Generator

This block produces the memory addresses and results for the two instructions that software uses to walk page tables by hand. The directory step takes a base value and a level number. It either fetches the next-level pointer from memory or, when the base already describes a huge page, tags the level into the entry without reading memory. The leaf step fetches the even or odd page-table entry into one of two refill-low registers. When the base is a huge page, the leaf step instead builds the entry for the requested half arithmetically. Both paths of the leaf step also update a refill page-size value.

The caller supplies the per-level index base and width fields, the entry-size code and the faulting virtual address. Each field is 6 bits for the base and 5 bits for the width. Slot 0 of the flat field vectors holds the page-table level and slots 1 to 4 hold directory levels 1 to 4. Entries are fetched through a single-beat memory port that uses a req/ack handshake. Only one operation runs at a time. `done` pulses for one cycle when the result is ready. The caller must hold the field inputs and the fault address stable while `busy` is high.

Top module: `pwalk_agen`

## Requirements
- R1: The index base and width come from field slot N for directory levels 1 to 4. A leaf load of a normal (non-huge) entry uses slot 0.
- R2: A directory step (`op`=0) with level 0 or a level above 4 returns the input base unchanged in `dir_result` and issues no memory request.
- R3: On a directory step where bit 6 (huge) of the base is set, no memory request is made. If the 2-bit level field at bits [14:13] of the base is zero, the result is the base with that field set to the request level. Otherwise the base is returned unchanged.
- R4: The entry-size code selects the index shift: codes 0, 1, 2 and 3 give shifts of 3, 6, 9 and 12 (that is, (code+1)*3).
- R5: A normal directory read uses address (base masked to 48 bits) OR (((va >> base_N) & (2^width_N - 1)) << shift). `dir_result` is the read data masked to 48 bits.
- R6: A normal leaf load (`op`=1) clears bit 0 of the slot-0 index. The even half reads at index<<shift and the odd half reads at (index+1)<<shift. The page size becomes the slot-0 base, and the stored entry is the read data masked to 48 bits.
- R7: A huge leaf load makes no request. It clears the level field and bit 6. If bit 12 (huge-global) is set, it clears bit 12 and sets bit 6 (global). The page size is base_L + width_L - 1, where L is the tagged level. The odd half adds 2^pagesize to the entry.
- R8: An odd leaf load writes `refill_lo1` and an even one writes `refill_lo0`. The other register keeps its value, and `refill_ps` is updated in both cases.
- R9: `mem_req` is raised only while busy. Once raised, it stays high with `mem_addr` stable until `mem_ack`, and each read-path operation issues exactly one request.
- R10: `done` is high for exactly one cycle per operation, and `busy` is low in that cycle. A `start` pulse while `busy` is high is ignored.
- R11: After reset, `busy`, `done`, `mem_req`, `dir_result`, `refill_lo0`, `refill_lo1` and `refill_ps` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op | input | 1 | 0 = directory step, 1 = leaf load |
| level | input | 3 | Directory level of the request |
| odd | input | 1 | Leaf load selects the odd half |
| base | input | 64 | Directory pointer, page-table base or huge entry |
| fault_va | input | 48 | Faulting virtual address |
| fld_base | input | 30 | Index base per slot, 6 bits each, slot 0 in the low bits |
| fld_width | input | 25 | Index width per slot, 5 bits each, slot 0 in the low bits |
| ent_code | input | 2 | Entry-size code |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 48 | Memory read address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| dir_result | output | 64 | Result of the last directory step |
| refill_lo0 | output | 64 | Even refill entry |
| refill_lo1 | output | 64 | Odd refill entry |
| refill_ps | output | 6 | Refill page size |

## Verification
The hardest case to reach from the ports is a second `start` arriving while a read is still in flight. The bench memory model holds off `mem_ack` for several cycles, which leaves time to pulse `start` with different operands. The bench then confirms that exactly one request was issued, that the result matches the first operation, and that no second `done` follows. The huge-leaf path is reached only through bases with bit 6 and a nonzero level tag. The bench crafts such bases both with and without bit 12 set, so that the global move and the odd-half addition are both observed.

// File: rtl/pwalk_pkg.sv
`timescale 1ns/1ps
// Shared types for the page-walk address generator.
package pwalk_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_DECIDE, ST_REQ} pw_state_e;
    typedef enum logic {OP_DIR = 1'b0, OP_LEAF = 1'b1} pw_op_e;
endpackage

// File: rtl/pwalk_field_sel.sv
`timescale 1ns/1ps
// Selects the index base and width for a level.
// Levels 1..NLVL pick their own slot; level 0 or out-of-range picks slot 0.
module pwalk_field_sel #(
    parameter int NLVL   = 4,
    parameter int LVL_IW = 3,
    parameter int BW     = 6,
    parameter int WW     = 5
) (
    input  logic [LVL_IW-1:0]        lvl,
    input  logic [(NLVL+1)*BW-1:0]   bases,
    input  logic [(NLVL+1)*WW-1:0]   widths,
    output logic [BW-1:0]            fbase,
    output logic [WW-1:0]            fwidth
);
    // Slot lookup with fallback to the page-table slot.
    always_comb begin
        int sel;
        sel = (lvl == '0 || int'(lvl) > NLVL) ? 0 : int'(lvl);
        fbase  = bases[sel*BW +: BW];
        fwidth = widths[sel*WW +: WW];
    end
endmodule

// File: rtl/pwalk_addr_calc.sv
`timescale 1ns/1ps
// Forms a table-entry address from base, faulting address and field.
// In pair mode bit 0 of the index is cleared and the odd flag is added.
module pwalk_addr_calc #(
    parameter int VA_W   = 48,
    parameter int DATA_W = 64,
    parameter int BW     = 6,
    parameter int WW     = 5
) (
    input  logic [VA_W-1:0]   va,
    input  logic [BW-1:0]     fbase,
    input  logic [WW-1:0]     fwidth,
    input  logic [1:0]        code,
    input  logic [DATA_W-1:0] base_m,
    input  logic              pair,
    input  logic              odd,
    output logic [DATA_W-1:0] addr
);
    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    // Index extraction, pairing and shift.
    always_comb begin
        logic [DATA_W-1:0] idx;
        logic [3:0]        sh;
        idx = (DATA_W'(va) >> fbase) & ((ONE << fwidth) - ONE);
        if (pair) begin
            idx = (idx & ~ONE) + (odd ? ONE : '0);
        end
        sh   = ({2'b00, code} + 4'd1) * 4'd3;
        addr = base_m | (idx << sh);
    end
endmodule

// File: rtl/pwalk_huge_fix.sv
`timescale 1ns/1ps
// Converts a tagged huge entry into one half of a refill pair.
// Assumes the field for the tagged level is already selected.
module pwalk_huge_fix #(
    parameter int DATA_W   = 64,
    parameter int BW       = 6,
    parameter int WW       = 5,
    parameter int HUGE_BIT = 6,
    parameter int G_BIT    = 6,
    parameter int HG_BIT   = 12,
    parameter int LVL_LSB  = 13,
    parameter int LVL_FW   = 2
) (
    input  logic [DATA_W-1:0] base_m,
    input  logic              odd,
    input  logic [BW-1:0]     fbase,
    input  logic [WW-1:0]     fwidth,
    output logic [DATA_W-1:0] entry,
    output logic [BW-1:0]     ps
);
    // Field clearing, global move and odd-half offset.
    always_comb begin
        logic [DATA_W-1:0] e;
        ps = fbase + BW'(fwidth) - BW'(1);
        e  = base_m;
        e[LVL_LSB +: LVL_FW] = '0;
        e[HUGE_BIT] = 1'b0;
        if (e[HG_BIT]) begin
            e[HG_BIT] = 1'b0;
            e[G_BIT]  = 1'b1;
        end
        entry = odd ? e + (DATA_W'(1) << ps) : e;
    end
endmodule

// File: rtl/pwalk_agen.sv
`timescale 1ns/1ps
// Page-walk address generator: runs one directory step or one leaf load.
// Assumes fault_va and field inputs stay stable while busy.
module pwalk_agen
    import pwalk_pkg::*;
#(
    parameter int NLVL     = 4,
    parameter int LVL_IW   = 3,
    parameter int VA_W     = 48,
    parameter int PA_W     = 48,
    parameter int DATA_W   = 64,
    parameter int BW       = 6,
    parameter int WW       = 5,
    parameter int HUGE_BIT = 6,
    parameter int G_BIT    = 6,
    parameter int HG_BIT   = 12,
    parameter int LVL_LSB  = 13,
    parameter int LVL_FW   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     op,
    input  logic [LVL_IW-1:0]        level,
    input  logic                     odd,
    input  logic [DATA_W-1:0]        base,
    input  logic [VA_W-1:0]          fault_va,
    input  logic [(NLVL+1)*BW-1:0]   fld_base,
    input  logic [(NLVL+1)*WW-1:0]   fld_width,
    input  logic [1:0]               ent_code,
    output logic                     mem_req,
    output logic [PA_W-1:0]          mem_addr,
    input  logic                     mem_ack,
    input  logic [DATA_W-1:0]        mem_rdata,
    output logic                     busy,
    output logic                     done,
    output logic [DATA_W-1:0]        dir_result,
    output logic [DATA_W-1:0]        refill_lo0,
    output logic [DATA_W-1:0]        refill_lo1,
    output logic [BW-1:0]            refill_ps
);
    localparam logic [DATA_W-1:0] PA_MASK = (DATA_W'(1) << PA_W) - DATA_W'(1);

    pw_state_e          state;
    pw_op_e             op_q;
    logic [LVL_IW-1:0]  lvl_q;
    logic               odd_q;
    logic [DATA_W-1:0]  base_q;
    logic [DATA_W-1:0]  base_m;
    logic               huge;
    logic               dir_bad;
    logic               need_read;
    logic [LVL_IW-1:0]  sel_lvl;
    logic [BW-1:0]      fb;
    logic [WW-1:0]      fw;
    logic [DATA_W-1:0]  calc_addr;
    logic [DATA_W-1:0]  huge_entry;
    logic [BW-1:0]      huge_ps;
    logic [DATA_W-1:0]  imm_val;
    logic [BW-1:0]      ps_val;
    logic               done_q;
    logic [DATA_W-1:0]  dir_q, lo0_q, lo1_q;
    logic [BW-1:0]      ps_q;

    // Decode of the latched request.
    always_comb begin
        base_m    = base_q & PA_MASK;
        huge      = base_q[HUGE_BIT];
        dir_bad   = (lvl_q == '0) || (int'(lvl_q) > NLVL);
        need_read = (op_q == OP_DIR) ? (!dir_bad && !huge) : !huge;
        if (op_q == OP_DIR)
            sel_lvl = lvl_q;
        else if (huge)
            sel_lvl = LVL_IW'(base_q[LVL_LSB +: LVL_FW]);
        else
            sel_lvl = '0;
    end

    pwalk_field_sel #(.NLVL(NLVL), .LVL_IW(LVL_IW), .BW(BW), .WW(WW)) u_fsel (
        .lvl(sel_lvl), .bases(fld_base), .widths(fld_width),
        .fbase(fb), .fwidth(fw)
    );

    pwalk_addr_calc #(.VA_W(VA_W), .DATA_W(DATA_W), .BW(BW), .WW(WW)) u_acalc (
        .va(fault_va), .fbase(fb), .fwidth(fw), .code(ent_code),
        .base_m(base_m), .pair(op_q == OP_LEAF), .odd(odd_q), .addr(calc_addr)
    );

    pwalk_huge_fix #(
        .DATA_W(DATA_W), .BW(BW), .WW(WW), .HUGE_BIT(HUGE_BIT), .G_BIT(G_BIT),
        .HG_BIT(HG_BIT), .LVL_LSB(LVL_LSB), .LVL_FW(LVL_FW)
    ) u_huge (
        .base_m(base_m), .odd(odd_q), .fbase(fb), .fwidth(fw),
        .entry(huge_entry), .ps(huge_ps)
    );

    // Result when no memory read is needed, and page size for leaf loads.
    always_comb begin
        imm_val = base_q;
        if (op_q == OP_DIR) begin
            if (!dir_bad && huge && base_q[LVL_LSB +: LVL_FW] == '0)
                imm_val[LVL_LSB +: LVL_FW] = lvl_q[LVL_FW-1:0];
        end else begin
            imm_val = huge_entry;
        end
        ps_val = huge ? huge_ps : fb;
    end

    // Control sequence and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            op_q   <= OP_DIR;
            lvl_q  <= '0;
            odd_q  <= 1'b0;
            base_q <= '0;
            done_q <= 1'b0;
            dir_q  <= '0;
            lo0_q  <= '0;
            lo1_q  <= '0;
            ps_q   <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        op_q   <= pw_op_e'(op);
                        lvl_q  <= level;
                        odd_q  <= odd;
                        base_q <= base;
                        state  <= ST_DECIDE;
                    end
                end
                ST_DECIDE: begin
                    if (need_read) begin
                        state <= ST_REQ;
                    end else begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                        if (op_q == OP_DIR) dir_q <= imm_val;
                        else begin
                            if (odd_q) lo1_q <= imm_val;
                            else       lo0_q <= imm_val;
                            ps_q <= ps_val;
                        end
                    end
                end
                ST_REQ: begin
                    if (mem_ack) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                        if (op_q == OP_DIR) dir_q <= mem_rdata & PA_MASK;
                        else begin
                            if (odd_q) lo1_q <= mem_rdata & PA_MASK;
                            else       lo0_q <= mem_rdata & PA_MASK;
                            ps_q <= ps_val;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mem_req    = (state == ST_REQ);
    assign mem_addr   = calc_addr[PA_W-1:0];
    assign busy       = (state != ST_IDLE);
    assign done       = done_q;
    assign dir_result = dir_q;
    assign refill_lo0 = lo0_q;
    assign refill_lo1 = lo1_q;
    assign refill_ps  = ps_q;
endmodule

// File: rtl/pwalk_agen_chk.sv
`timescale 1ns/1ps
// Protocol checker for pwalk_agen, observing its ports only.
module pwalk_agen_chk #(
    parameter int PA_W   = 48,
    parameter int DATA_W = 64,
    parameter int BW     = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic [PA_W-1:0]   mem_addr,
    input logic              mem_ack,
    input logic              busy,
    input logic              done,
    input logic [DATA_W-1:0] refill_lo0,
    input logic [DATA_W-1:0] refill_lo1,
    input logic [BW-1:0]     refill_ps
);
    AST_DONE_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);                        // R10
    AST_DONE_IDLE:     assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);                        // R10
    AST_REQ_HELD:      assert property (@(posedge clk) disable iff (!rst_n) (mem_req && !mem_ack) |=> mem_req);    // R9
    AST_ADDR_STABLE:   assert property (@(posedge clk) disable iff (!rst_n) (mem_req && !mem_ack) |=> $stable(mem_addr)); // R9
    AST_REQ_BUSY:      assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> busy);                      // R9
    AST_LO0_AT_DONE:   assert property (@(posedge clk) disable iff (!rst_n) !$stable(refill_lo0) |-> done);         // R8
    AST_LO1_AT_DONE:   assert property (@(posedge clk) disable iff (!rst_n) !$stable(refill_lo1) |-> done);         // R8
    AST_PS_AT_DONE:    assert property (@(posedge clk) disable iff (!rst_n) !$stable(refill_ps) |-> done);          // R8
endmodule

bind pwalk_agen pwalk_agen_chk #(.PA_W(PA_W), .DATA_W(DATA_W), .BW(BW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .busy(busy), .done(done), .refill_lo0(refill_lo0),
    .refill_lo1(refill_lo1), .refill_ps(refill_ps)
);

// File: tb/pwalk_agen_tb_top.sv
`timescale 1ns/1ps
module pwalk_agen_tb_top;
    localparam logic [47:0] KEY = 48'h5A5A_0000_0000;
    localparam logic [47:0] VA  = 48'h7F12_3456_7ABC;
    localparam int          LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, op = 1'b0, odd = 1'b0;
    logic [2:0]  level = '0;
    logic [63:0] base = '0;
    logic [47:0] fault_va = VA;
    logic [29:0] fld_base;
    logic [24:0] fld_width;
    logic [1:0]  ent_code = 2'd0;
    logic        mem_req, mem_ack;
    logic [47:0] mem_addr;
    logic [63:0] mem_rdata;
    logic        busy, done;
    logic [63:0] dir_result, refill_lo0, refill_lo1;
    logic [5:0]  refill_ps;

    int n_chk = 0, n_bad = 0, req_cnt = 0, ack_dly = 0;
    logic [47:0] last_addr = '0;

    // slot0: 12/9, slot1: 21/9, slot2: 30/9, slot3: 39/9, slot4: 40/4
    assign fld_base  = {6'd40, 6'd39, 6'd30, 6'd21, 6'd12};
    assign fld_width = {5'd4, 5'd9, 5'd9, 5'd9, 5'd9};

    always #2 clk = ~clk;

    pwalk_agen dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .level(level), .odd(odd),
        .base(base), .fault_va(fault_va), .fld_base(fld_base), .fld_width(fld_width),
        .ent_code(ent_code), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .dir_result(dir_result),
        .refill_lo0(refill_lo0), .refill_lo1(refill_lo1), .refill_ps(refill_ps)
    );

    // Memory model: data encodes the address, upper bits carry junk.
    assign mem_rdata = {16'hBEEF, mem_addr ^ KEY};
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0; ack_dly <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0; ack_dly <= 0;
        end else if (mem_req) begin
            if (ack_dly == LAT) begin
                mem_ack <= 1'b1; req_cnt <= req_cnt + 1; last_addr <= mem_addr;
            end else ack_dly <= ack_dly + 1;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Issue one operation and wait for its done pulse; checks pulse width.
    task automatic run_op(input logic o, input logic [2:0] l, input logic od, input logic [63:0] b);
        int w = 0;
        @(negedge clk);
        op = o; level = l; odd = od; base = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && w < 50) begin @(negedge clk); w++; end
        chk("R10 done seen", 64'(done), 64'd1);
        chk("R10 idle at done", 64'(busy), 64'd0);
        @(negedge clk);
        chk("R10 done one cycle", 64'(done), 64'd0);
    endtask

    task automatic t_reset();
        chk("R11 busy", 64'(busy), 0);
        chk("R11 done", 64'(done), 0);
        chk("R11 req", 64'(mem_req), 0);
        chk("R11 dir_result", dir_result, 0);
        chk("R11 lo0", refill_lo0, 0);
        chk("R11 lo1", refill_lo1, 0);
        chk("R11 ps", 64'(refill_ps), 0);
    endtask

    task automatic t_dir_read();
        logic [63:0] b, ea;
        int r0;
        b = 64'h0000_0000_0010_0000; ent_code = 2'd0; r0 = req_cnt;
        ea = b | ((((64'(VA)) >> 21) & 64'h1FF) << 3);
        run_op(1'b0, 3'd1, 1'b0, b);
        chk("R5 R1 level1 addr", 64'(last_addr), ea);
        chk("R5 level1 data", dir_result, 64'(ea[47:0] ^ KEY));
        chk("R9 one request", 64'(req_cnt - r0), 1);
        b = 64'hF000_0000_0200_0000; ent_code = 2'd2;
        ea = (b & 64'h0000_FFFF_FFFF_FFFF) | ((((64'(VA)) >> 39) & 64'h1FF) << 9);
        run_op(1'b0, 3'd3, 1'b0, b);
        chk("R4 R1 level3 shift9 addr", 64'(last_addr), ea);
        chk("R5 level3 data masked", dir_result, 64'(ea[47:0] ^ KEY));
        b = 64'h0000_0000_0300_0000; ent_code = 2'd3;
        ea = b | ((((64'(VA)) >> 40) & 64'hF) << 12);
        run_op(1'b0, 3'd4, 1'b0, b);
        chk("R4 R1 level4 shift12 addr", 64'(last_addr), ea);
    endtask

    task automatic t_dir_bad_level();
        int r0 = req_cnt;
        run_op(1'b0, 3'd0, 1'b0, 64'hF000_0000_0000_1234);
        chk("R2 level0 unchanged", dir_result, 64'hF000_0000_0000_1234);
        run_op(1'b0, 3'd5, 1'b0, 64'h8000_0000_0000_5678);
        chk("R2 level5 unchanged", dir_result, 64'h8000_0000_0000_5678);
        chk("R2 no request", 64'(req_cnt - r0), 0);
    endtask

    task automatic t_dir_huge();
        int r0 = req_cnt;
        run_op(1'b0, 3'd2, 1'b0, 64'h0000_0000_1234_0040);
        chk("R3 tag level2", dir_result, 64'h0000_0000_1234_4040);
        run_op(1'b0, 3'd3, 1'b0, 64'h0000_0000_1234_2040);
        chk("R3 already tagged", dir_result, 64'h0000_0000_1234_2040);
        chk("R3 no request", 64'(req_cnt - r0), 0);
    endtask

    task automatic t_leaf_normal();
        logic [63:0] bm, idx, ea;
        logic [63:0] lo1_before;
        ent_code = 2'd1;
        bm  = 64'h0000_0000_0080_0000;
        idx = ((64'(VA)) >> 12) & 64'h1FE;
        lo1_before = refill_lo1;
        run_op(1'b1, 3'd0, 1'b0, 64'hC000_0000_0080_0000);
        ea = bm | (idx << 6);
        chk("R6 even addr", 64'(last_addr), ea);
        chk("R8 even to lo0", refill_lo0, 64'(ea[47:0] ^ KEY));
        chk("R8 lo1 kept", refill_lo1, lo1_before);
        chk("R6 ps pt base", 64'(refill_ps), 12);
        run_op(1'b1, 3'd0, 1'b1, 64'hC000_0000_0080_0000);
        ea = bm | ((idx + 1) << 6);
        chk("R6 odd addr", 64'(last_addr), ea);
        chk("R8 odd to lo1", refill_lo1, 64'(ea[47:0] ^ KEY));
        chk("R8 lo0 kept", refill_lo0, 64'(((bm | (idx << 6)) ^ 64'(KEY)) & 64'h0000_FFFF_FFFF_FFFF));
    endtask

    task automatic t_leaf_huge();
        int r0 = req_cnt;
        run_op(1'b1, 3'd0, 1'b0, 64'h0000_0000_4000_3040);
        chk("R7 even global moved", refill_lo0, 64'h0000_0000_4000_0040);
        chk("R7 ps level1", 64'(refill_ps), 29);
        run_op(1'b1, 3'd0, 1'b1, 64'h0000_0000_4000_3040);
        chk("R7 odd half", refill_lo1, 64'h0000_0000_6000_0040);
        run_op(1'b1, 3'd0, 1'b1, 64'h0000_0000_4000_4040);
        chk("R7 odd level2 no global", refill_lo1, 64'h0000_0040_4000_0000);
        chk("R7 ps level2", 64'(refill_ps), 38);
        chk("R7 no request", 64'(req_cnt - r0), 0);
    endtask

    task automatic t_busy_ignore();
        logic [63:0] b, ea;
        int r0 = req_cnt;
        int w = 0;
        int extra = 0;
        b = 64'h0000_0000_0010_0000; ent_code = 2'd0;
        ea = b | ((((64'(VA)) >> 21) & 64'h1FF) << 3);
        @(negedge clk);
        op = 1'b0; level = 3'd1; odd = 1'b0; base = b; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        op = 1'b0; level = 3'd0; base = 64'hDEAD_0000_0000_0000; start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!done && w < 50) begin @(negedge clk); w++; end
        chk("R10 first op result", dir_result, 64'(ea[47:0] ^ KEY));
        for (int i = 0; i < 8; i++) begin @(negedge clk); if (done) extra++; end
        chk("R10 ignored start no done", 64'(extra), 0);
        chk("R10 one request", 64'(req_cnt - r0), 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dir_read();
        t_dir_bad_level();
        t_dir_huge();
        t_leaf_normal();
        t_leaf_huge();
        t_busy_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule